// File: doc/BRIEF.md
# Debug Hit Qualifier

This block sits behind the address comparators of a breakpoint or watchpoint unit. An address comparator that has already hit presents its hit to this block. The block also presents the control fields of the hitting comparator. The block then decides whether the hit may raise a debug event. It checks three things. The first is the security-state selector. The second is a privilege decode for the level of the access. The third is an optional link to one of the context-aware comparators, whose stored value must equal a context ID chosen by level and hypervisor controls.

The decision is registered. The qualified hit appears one clock after the inputs that produce it. The number of comparators and the number of context-aware comparators are parameters. The context-aware comparators are always the highest-numbered ones. The context table is presented flat: entry k of the table describes comparator `NUM_CMP-NUM_CTX+k`.

Top module: `dbg_hit_qualify`

## Requirements
- R1: `qual_hit` is 0 while reset is held. After reset, on each clock edge it takes the value of `hit_in` ANDed with the outcome of every qualification check. With `hit_in` low it is 0 the next cycle.
- R2: The security selector `sec_sel` is decoded as follows. Value 0 passes in either state. Values 1 and 3 pass only when `secure` is 0. Value 2 passes only when `secure` is 1.
- R3: At access level 2 or 3 the hit needs `hmode_en` = 1. At level 1 it needs `priv_ctl[0]` = 1. At level 0 it needs `priv_ctl[1]` = 1.
- R4: When `is_watch` = 1 and `unpriv_acc` = 1, the R3 check uses access level 0 whatever `cur_lvl` is. For a breakpoint (`is_watch` = 0), `unpriv_acc` has no effect.
- R5: When `link_en` = 0, `link_idx` is ignored. When `link_en` = 1, `link_idx` must lie in [NUM_CMP-NUM_CTX, NUM_CMP-1], otherwise the hit fails. Entry k = `link_idx`-(NUM_CMP-NUM_CTX) of the context table is used.
- R6: A linked context entry whose enable bit `ctx_en[k]` is 0 fails the hit.
- R7: Context type 3 compares against the ID of the current level `cur_lvl` (not the access level of R4). At level 3 it always fails. At level 2 it uses `cid_l2` only when `host_ext` = 1, and fails otherwise. At level 1 it uses `cid_l1`. At level 0 it uses `cid_l2` when `host_ext` and `trap_gen` are both 1, and `cid_l1` otherwise.
- R8: Context type 7 compares against `cid_l1` and type 13 against `cid_l2`. Every other type value fails the hit.
- R9: The context comparison is an exact equality over all 32 bits of the entry value. A single differing bit fails the hit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hit_in | input | 1 | Address comparator hit |
| is_watch | input | 1 | 1: watchpoint hit, 0: breakpoint hit |
| unpriv_acc | input | 1 | Hit came from an unprivileged load/store |
| sec_sel | input | 2 | Security-state selector field |
| hmode_en | input | 1 | Enable for levels 2 and 3 |
| priv_ctl | input | 2 | Bit 0 enables level 1, bit 1 enables level 0 |
| link_en | input | 1 | Hit is linked to a context comparator |
| link_idx | input | clog2(NUM_CMP) | Index of the linked comparator |
| cur_lvl | input | 2 | Current privilege level 0..3 |
| secure | input | 1 | 1 when in secure state |
| ctx_en | input | NUM_CTX | Enable bit of each context entry |
| ctx_type | input | 4*NUM_CTX | 4-bit type of each context entry, entry k at [4k+3:4k] |
| ctx_val | input | 32*NUM_CTX | Value of each context entry, entry k at [32k+31:32k] |
| cid_l1 | input | 32 | Level-1 context ID |
| cid_l2 | input | 32 | Level-2 context ID |
| host_ext | input | 1 | Host-extension control bit |
| trap_gen | input | 1 | Trap-general control bit |
| qual_hit | output | 1 | Registered qualified hit |

## Verification
The bench targets several corner cases:
- An unprivileged watchpoint access at level 1. A design that applied the level-0 substitution to breakpoints too, or also fed it into the type-3 source choice, would give the wrong verdict.
- The link index just below the context-aware range. An off-by-one range check would let a hit through there.
- Type 3 at levels 2 and 3 with every setting of the hypervisor bits. A wrong source choice would compare against the wrong ID.
- A context value that differs only in its top bit. A truncated comparison would wrongly accept it.
- Reserved selector value 3 and reserved context types, which a sloppy decode would treat as wildcards.

// File: rtl/dbgq_pkg.sv
`timescale 1ns/1ps
package dbgq_pkg;

  localparam logic [3:0] CTX_T_CUR = 4'd3;
  localparam logic [3:0] CTX_T_L1  = 4'd7;
  localparam logic [3:0] CTX_T_L2  = 4'd13;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_L1   = 2'd1,
    SRC_L2   = 2'd2
  } ctx_src_e;

  // security selector decode
  function automatic logic sec_match(input logic [1:0] sel, input logic is_sec);
    case (sel)
      2'd0:    return 1'b1;
      2'd2:    return is_sec;
      default: return ~is_sec;
    endcase
  endfunction

  // level the privilege check is made at
  function automatic logic [1:0] access_level(input logic [1:0] lvl,
                                              input logic watch,
                                              input logic unpriv);
    return (watch && unpriv) ? 2'd0 : lvl;
  endfunction

  function automatic logic priv_match(input logic [1:0] lvl,
                                      input logic hm,
                                      input logic [1:0] pac);
    case (lvl)
      2'd0:    return pac[1];
      2'd1:    return pac[0];
      default: return hm;
    endcase
  endfunction

  // which context ID a linked entry compares against
  function automatic ctx_src_e ctx_source(input logic [3:0] ty,
                                          input logic [1:0] lvl,
                                          input logic host,
                                          input logic trap);
    if (ty == CTX_T_L1) return SRC_L1;
    if (ty == CTX_T_L2) return SRC_L2;
    if (ty != CTX_T_CUR) return SRC_NONE;
    case (lvl)
      2'd3: return SRC_NONE;
      2'd2: return host ? SRC_L2 : SRC_NONE;
      2'd1: return SRC_L1;
      default: return (host && trap) ? SRC_L2 : SRC_L1;
    endcase
  endfunction

endpackage

// File: rtl/dbgq_state_check.sv
`timescale 1ns/1ps
module dbgq_state_check
  import dbgq_pkg::*;
(
  input  logic [1:0] sec_sel,
  input  logic       secure,
  input  logic       hmode_en,
  input  logic [1:0] priv_ctl,
  input  logic [1:0] cur_lvl,
  input  logic       is_watch,
  input  logic       unpriv_acc,
  output logic       sec_ok,
  output logic       priv_ok
);

  logic [1:0] acc_lvl;

  always_comb begin
    acc_lvl = access_level(cur_lvl, is_watch, unpriv_acc);
    sec_ok  = sec_match(sec_sel, secure);
    priv_ok = priv_match(acc_lvl, hmode_en, priv_ctl);
  end

endmodule

// File: rtl/dbgq_ctx_pick.sv
`timescale 1ns/1ps
module dbgq_ctx_pick #(
  parameter int NUM_CMP = 16,
  parameter int NUM_CTX = 4,
  parameter int CID_W   = 32,
  localparam int IDX_W  = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1,
  localparam int BASE   = NUM_CMP - NUM_CTX
) (
  input  logic [IDX_W-1:0]       link_idx,
  input  logic [NUM_CTX-1:0]     ctx_en,
  input  logic [4*NUM_CTX-1:0]   ctx_type,
  input  logic [CID_W*NUM_CTX-1:0] ctx_val,
  output logic                   idx_ok,
  output logic                   sel_en,
  output logic [3:0]             sel_type,
  output logic [CID_W-1:0]       sel_val
);

  logic [NUM_CTX-1:0] onehot;

  for (genvar k = 0; k < NUM_CTX; k++) begin : g_dec
    assign onehot[k] = (int'(link_idx) == BASE + k);
  end

  always_comb begin
    idx_ok   = (int'(link_idx) >= BASE) && (int'(link_idx) < NUM_CMP);
    sel_en   = 1'b0;
    sel_type = '0;
    sel_val  = '0;
    for (int k = 0; k < NUM_CTX; k++) begin
      if (onehot[k]) begin
        sel_en   = sel_en   | ctx_en[k];
        sel_type = sel_type | ctx_type[4*k +: 4];
        sel_val  = sel_val  | ctx_val[CID_W*k +: CID_W];
      end
    end
  end

endmodule

// File: rtl/dbgq_ctx_match.sv
`timescale 1ns/1ps
module dbgq_ctx_match
  import dbgq_pkg::*;
#(
  parameter int CID_W = 32
) (
  input  logic [3:0]       sel_type,
  input  logic [CID_W-1:0] sel_val,
  input  logic [1:0]       cur_lvl,
  input  logic             host_ext,
  input  logic             trap_gen,
  input  logic [CID_W-1:0] cid_l1,
  input  logic [CID_W-1:0] cid_l2,
  output logic             ctx_ok
);

  ctx_src_e src;

  always_comb begin
    src = ctx_source(sel_type, cur_lvl, host_ext, trap_gen);
    case (src)
      SRC_L1:  ctx_ok = (sel_val == cid_l1);
      SRC_L2:  ctx_ok = (sel_val == cid_l2);
      default: ctx_ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/dbg_hit_qualify.sv
`timescale 1ns/1ps
module dbg_hit_qualify #(
  parameter int NUM_CMP = 16,
  parameter int NUM_CTX = 4,
  localparam int CID_W  = 32,
  localparam int IDX_W  = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     hit_in,
  input  logic                     is_watch,
  input  logic                     unpriv_acc,
  input  logic [1:0]               sec_sel,
  input  logic                     hmode_en,
  input  logic [1:0]               priv_ctl,
  input  logic                     link_en,
  input  logic [IDX_W-1:0]         link_idx,
  input  logic [1:0]               cur_lvl,
  input  logic                     secure,
  input  logic [NUM_CTX-1:0]       ctx_en,
  input  logic [4*NUM_CTX-1:0]     ctx_type,
  input  logic [CID_W*NUM_CTX-1:0] ctx_val,
  input  logic [CID_W-1:0]         cid_l1,
  input  logic [CID_W-1:0]         cid_l2,
  input  logic                     host_ext,
  input  logic                     trap_gen,
  output logic                     qual_hit
);

  initial begin
    if (NUM_CTX < 1 || NUM_CTX > NUM_CMP)
      $error("dbg_hit_qualify: NUM_CTX must be in 1..NUM_CMP");
  end

  // named internal events, visible to the checker
  logic             w_sec_ok;
  logic             w_priv_ok;
  logic             w_idx_ok;
  logic             w_sel_en;
  logic [3:0]       w_sel_type;
  logic [CID_W-1:0] w_sel_val;
  logic             w_ctx_ok;
  logic             w_link_ok;
  logic             w_qual_d;

  dbgq_state_check u_state (
    .sec_sel    (sec_sel),
    .secure     (secure),
    .hmode_en   (hmode_en),
    .priv_ctl   (priv_ctl),
    .cur_lvl    (cur_lvl),
    .is_watch   (is_watch),
    .unpriv_acc (unpriv_acc),
    .sec_ok     (w_sec_ok),
    .priv_ok    (w_priv_ok)
  );

  dbgq_ctx_pick #(
    .NUM_CMP (NUM_CMP),
    .NUM_CTX (NUM_CTX),
    .CID_W   (CID_W)
  ) u_pick (
    .link_idx (link_idx),
    .ctx_en   (ctx_en),
    .ctx_type (ctx_type),
    .ctx_val  (ctx_val),
    .idx_ok   (w_idx_ok),
    .sel_en   (w_sel_en),
    .sel_type (w_sel_type),
    .sel_val  (w_sel_val)
  );

  dbgq_ctx_match #(
    .CID_W (CID_W)
  ) u_match (
    .sel_type (w_sel_type),
    .sel_val  (w_sel_val),
    .cur_lvl  (cur_lvl),
    .host_ext (host_ext),
    .trap_gen (trap_gen),
    .cid_l1   (cid_l1),
    .cid_l2   (cid_l2),
    .ctx_ok   (w_ctx_ok)
  );

  assign w_link_ok = ~link_en | (w_idx_ok & w_sel_en & w_ctx_ok);
  assign w_qual_d  = hit_in & w_sec_ok & w_priv_ok & w_link_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) qual_hit <= 1'b0;
    else        qual_hit <= w_qual_d;
  end

endmodule

// File: rtl/dbgq_checker.sv
`timescale 1ns/1ps
module dbgq_checker #(
  parameter int NUM_CMP = 16,
  parameter int NUM_CTX = 4,
  localparam int IDX_W  = (NUM_CMP > 1) ? $clog2(NUM_CMP) : 1,
  localparam int BASE   = NUM_CMP - NUM_CTX
) (
  input logic             clk,
  input logic             rst_n,
  input logic             hit_in,
  input logic             secure,
  input logic [1:0]       sec_sel,
  input logic [1:0]       cur_lvl,
  input logic [1:0]       priv_ctl,
  input logic             is_watch,
  input logic             unpriv_acc,
  input logic             link_en,
  input logic [IDX_W-1:0] link_idx,
  input logic             idx_ok,
  input logic             sel_en,
  input logic [3:0]       sel_type,
  input logic             qual_hit
);

  assert_no_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_in |=> !qual_hit);

  assert_sec_block_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (secure && sec_sel == 2'd1) || (!secure && sec_sel == 2'd2) |=> !qual_hit);

  assert_priv_l1_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cur_lvl == 2'd1 && !priv_ctl[0] && !(is_watch && unpriv_acc) |=> !qual_hit);

  assert_unpriv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    is_watch && unpriv_acc && !priv_ctl[1] |=> !qual_hit);

  assert_link_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    link_en && (int'(link_idx) < BASE) |=> !qual_hit);

  assert_ctx_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    link_en && idx_ok && !sel_en |=> !qual_hit);

  assert_cur_l3_R7: assert property (@(posedge clk) disable iff (!rst_n)
    link_en && idx_ok && sel_type == 4'd3 && cur_lvl == 2'd3 |=> !qual_hit);

  assert_bad_type_R8: assert property (@(posedge clk) disable iff (!rst_n)
    link_en && idx_ok && sel_type != 4'd3 && sel_type != 4'd7 && sel_type != 4'd13
    |=> !qual_hit);

endmodule

bind dbg_hit_qualify dbgq_checker #(
  .NUM_CMP (NUM_CMP),
  .NUM_CTX (NUM_CTX)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .hit_in     (hit_in),
  .secure     (secure),
  .sec_sel    (sec_sel),
  .cur_lvl    (cur_lvl),
  .priv_ctl   (priv_ctl),
  .is_watch   (is_watch),
  .unpriv_acc (unpriv_acc),
  .link_en    (link_en),
  .link_idx   (link_idx),
  .idx_ok     (w_idx_ok),
  .sel_en     (w_sel_en),
  .sel_type   (w_sel_type),
  .qual_hit   (qual_hit)
);

// File: tb/dbg_hit_qualify_tb.sv
`timescale 1ns/1ps
module dbg_hit_qualify_tb_top;

  localparam int NUM_CMP = 16;
  localparam int NUM_CTX = 4;
  localparam int IDX_W   = $clog2(NUM_CMP);
  localparam int LOW     = NUM_CMP - NUM_CTX;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic             hit_in, is_watch, unpriv_acc, hmode_en, link_en, secure;
  logic             host_ext, trap_gen;
  logic [1:0]       sec_sel, priv_ctl, cur_lvl;
  logic [IDX_W-1:0] link_idx;
  logic [31:0]      cid_l1, cid_l2;
  logic             t_en  [NUM_CTX];
  logic [3:0]       t_ty  [NUM_CTX];
  logic [31:0]      t_val [NUM_CTX];
  logic [NUM_CTX-1:0]    ctx_en;
  logic [4*NUM_CTX-1:0]  ctx_type;
  logic [32*NUM_CTX-1:0] ctx_val;
  logic             qual_hit;

  always_comb begin
    for (int k = 0; k < NUM_CTX; k++) begin
      ctx_en[k]            = t_en[k];
      ctx_type[4*k +: 4]   = t_ty[k];
      ctx_val[32*k +: 32]  = t_val[k];
    end
  end

  dbg_hit_qualify #(.NUM_CMP(NUM_CMP), .NUM_CTX(NUM_CTX)) dut_i (
    .clk(clk), .rst_n(rst_n), .hit_in(hit_in), .is_watch(is_watch),
    .unpriv_acc(unpriv_acc), .sec_sel(sec_sel), .hmode_en(hmode_en),
    .priv_ctl(priv_ctl), .link_en(link_en), .link_idx(link_idx),
    .cur_lvl(cur_lvl), .secure(secure), .ctx_en(ctx_en), .ctx_type(ctx_type),
    .ctx_val(ctx_val), .cid_l1(cid_l1), .cid_l2(cid_l2), .host_ext(host_ext),
    .trap_gen(trap_gen), .qual_hit(qual_hit)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural model written from the requirements
  function automatic bit model();
    int  lv;
    bit  s_ok, p_ok, l_ok;
    int  e;
    s_ok = (sec_sel == 0) ? 1'b1 : (sec_sel == 2) ? secure : !secure;
    lv = (is_watch && unpriv_acc) ? 0 : int'(cur_lvl);
    if (lv >= 2)      p_ok = hmode_en;
    else if (lv == 1) p_ok = priv_ctl[0];
    else              p_ok = priv_ctl[1];
    if (!link_en) l_ok = 1'b1;
    else if (int'(link_idx) < LOW || int'(link_idx) >= NUM_CMP) l_ok = 1'b0;
    else begin
      e = int'(link_idx) - LOW;
      if (!t_en[e]) l_ok = 1'b0;
      else if (t_ty[e] == 4'd7)  l_ok = (t_val[e] == cid_l1);
      else if (t_ty[e] == 4'd13) l_ok = (t_val[e] == cid_l2);
      else if (t_ty[e] == 4'd3) begin
        if (cur_lvl == 3)      l_ok = 1'b0;
        else if (cur_lvl == 2) l_ok = host_ext && (t_val[e] == cid_l2);
        else if (cur_lvl == 1) l_ok = (t_val[e] == cid_l1);
        else l_ok = (host_ext && trap_gen) ? (t_val[e] == cid_l2) : (t_val[e] == cid_l1);
      end
      else l_ok = 1'b0;
    end
    return hit_in && s_ok && p_ok && l_ok;
  endfunction

  task automatic step(input string req);
    bit exp_v;
    exp_v = model();
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (qual_hit !== exp_v) begin
      errors++;
      $display("FAIL %s: qual_hit=%0b expected %0b", req, qual_hit, exp_v);
    end
  endtask

  task automatic expect_now(input string req, input bit exp_v);
    checks++;
    if (qual_hit !== exp_v) begin
      errors++;
      $display("FAIL %s: qual_hit=%0b expected %0b", req, qual_hit, exp_v);
    end
  endtask

  task automatic base_pass();
    hit_in = 1; is_watch = 0; unpriv_acc = 0; sec_sel = 0; secure = 0;
    hmode_en = 1; priv_ctl = 2'b11; cur_lvl = 1; link_en = 0; link_idx = '0;
    host_ext = 0; trap_gen = 0;
    cid_l1 = 32'h1234_5678; cid_l2 = 32'h9abc_def0;
    for (int k = 0; k < NUM_CTX; k++) begin
      t_en[k] = 1; t_ty[k] = 4'd7; t_val[k] = cid_l1;
    end
  endtask

  initial begin
    base_pass();
    hit_in = 1;
    repeat (3) @(negedge clk);
    expect_now("R1 reset", 1'b0);
    rst_n = 1'b1;

    // R1
    step("R1 pass");
    hit_in = 0; step("R1 no hit");
    // R2
    base_pass(); sec_sel = 1; secure = 1; step("R2 sel1 secure");
    sec_sel = 3; secure = 0; step("R2 sel3 nonsecure");
    sec_sel = 3; secure = 1; step("R2 sel3 secure");
    sec_sel = 2; secure = 0; step("R2 sel2 nonsecure");
    sec_sel = 2; secure = 1; step("R2 sel2 secure");
    // R3
    base_pass(); cur_lvl = 0; priv_ctl = 2'b01; step("R3 l0 no bit1");
    priv_ctl = 2'b10; step("R3 l0 bit1");
    cur_lvl = 1; step("R3 l1 no bit0");
    cur_lvl = 2; hmode_en = 0; priv_ctl = 2'b11; step("R3 l2 no hmode");
    cur_lvl = 3; hmode_en = 1; priv_ctl = 2'b00; step("R3 l3 hmode");
    // R4
    base_pass(); is_watch = 1; unpriv_acc = 1; priv_ctl = 2'b01; step("R4 unpriv watch");
    priv_ctl = 2'b10; cur_lvl = 2; hmode_en = 0; step("R4 unpriv watch at l2");
    is_watch = 0; priv_ctl = 2'b01; cur_lvl = 1; hmode_en = 1; step("R4 breakpoint ignores unpriv");
    // R5
    base_pass(); link_en = 1; link_idx = IDX_W'(LOW - 1); step("R5 below range");
    link_idx = IDX_W'(LOW); step("R5 low edge");
    link_idx = IDX_W'(NUM_CMP - 1); step("R5 high edge");
    t_val[NUM_CTX-1] = 32'h0; step("R5 entry select");
    link_en = 0; link_idx = 3; step("R5 link off ignores idx");
    // R6
    base_pass(); link_en = 1; link_idx = IDX_W'(LOW + 1); t_en[1] = 0; step("R6 disabled entry");
    // R7
    base_pass(); link_en = 1; link_idx = IDX_W'(LOW + 2); t_ty[2] = 4'd3;
    cur_lvl = 3; t_val[2] = cid_l2; host_ext = 1; step("R7 l3 never");
    cur_lvl = 2; host_ext = 0; step("R7 l2 no host");
    host_ext = 1; step("R7 l2 host");
    cur_lvl = 0; trap_gen = 1; step("R7 l0 host trap");
    trap_gen = 0; step("R7 l0 host only uses l1");
    t_val[2] = cid_l1; step("R7 l0 l1 id");
    cur_lvl = 1; is_watch = 1; unpriv_acc = 1; host_ext = 1; trap_gen = 1;
    step("R7 unpriv uses current level");
    // R8
    base_pass(); link_en = 1; link_idx = IDX_W'(LOW); t_ty[0] = 4'd13; t_val[0] = cid_l2;
    step("R8 type13");
    t_ty[0] = 4'd9; step("R8 reserved type");
    t_ty[0] = 4'd7; t_val[0] = cid_l2; step("R8 type7 wrong id");
    // R9
    base_pass(); link_en = 1; link_idx = IDX_W'(LOW); t_val[0] = cid_l1 ^ 32'h8000_0000;
    step("R9 top bit");
    t_val[0] = cid_l1 ^ 32'h1; step("R9 low bit");

    // constrained random
    begin
      int seed_dummy;
      seed_dummy = $urandom(32'h5eed_1234);
    end
    for (int i = 0; i < 800; i++) begin
      hit_in     = ($urandom % 8) != 0;
      is_watch   = $urandom % 2;
      unpriv_acc = $urandom % 2;
      sec_sel    = 2'($urandom % 4);
      secure     = $urandom % 2;
      hmode_en   = $urandom % 2;
      priv_ctl   = 2'($urandom % 4);
      link_en    = $urandom % 2;
      link_idx   = IDX_W'(LOW - 2 + int'($urandom % (NUM_CTX + 2)));
      cur_lvl    = 2'($urandom % 4);
      host_ext   = $urandom % 2;
      trap_gen   = $urandom % 2;
      cid_l1     = $urandom;
      cid_l2     = $urandom;
      for (int k = 0; k < NUM_CTX; k++) begin
        int r;
        t_en[k] = ($urandom % 5) != 0;
        r = int'($urandom % 5);
        t_ty[k] = (r == 0) ? 4'd3 : (r == 1) ? 4'd7 : (r == 2) ? 4'd13 :
                  (r == 3) ? 4'd3 : 4'($urandom);
        r = int'($urandom % 4);
        t_val[k] = (r == 0) ? cid_l1 : (r == 1) ? cid_l2 :
                   (r == 2) ? (cid_l1 ^ (32'h1 << ($urandom % 32))) : $urandom;
      end
      step("R1-random");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: qual_hit=%0b expected completion", qual_hit);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule